// File: doc/BRIEF.md
# Message Reassembly and Arrival Tracker

This block sits on the receive side of a network interface. Before a message leaves the local node, software or a send engine registers it in a small table, giving its message number and its packet count. The router's ejection port then reports one notice per packet, carrying the message number and the packet index. Each notice is given at the moment the packet's final flit leaves the router. The tracker marks which packets of each message have arrived, counts down the packets still missing, and decides when the message is whole.

Packets of one message may arrive in any order, and several messages may be in flight at once. When the last missing packet of a message arrives, the tracker waits a fixed receiver transfer delay and then emits a one-cycle arrival pulse to the local processor. The pulse carries the message number, the cycle in which the message was registered, and the cycle of the arrival itself. Notices that cannot be matched to a live, incomplete message are dropped and raise a sticky error flag. Registrations that hit an occupied table slot are treated the same way. A slot becomes free again in the cycle its arrival pulse is issued.

Top module: `reasm_tracker`

## Requirements
- R1: After reset, `arr_valid` and `err` are 0 and every table slot is free.
- R2: A registration (`reg_valid`) into a free slot is accepted. It stores a packet count of `reg_last`+1 (1 to 4 packets with the default widths) and the registration cycle's timestamp. The slot is selected directly by the message number.
- R3: A message completes when each packet index 0..`reg_last` has been reported once, in any order. Messages held in different slots progress independently and may interleave.
- R4: If the final missing packet is reported in cycle T, `arr_valid` is 1 in cycle T+DELAY only, with `arr_msg` set to that message number.
- R5: A free-running cycle counter reads 0 in the first cycle after a cycle with `rst` high and then rises by one per cycle. `arr_time` equals the counter value in the arrival cycle, and `arr_sent` equals the counter value in the registration cycle.
- R6: A slot is freed in its arrival cycle. A registration for that message number in the arrival cycle itself is accepted, and a notice for the message after its arrival is treated as unknown.
- R7: A notice for a message number whose slot is free sets `err` and changes no table state.
- R8: A notice whose packet index was already reported, or exceeds the message's `reg_last`, sets `err` and is not counted toward completion.
- R9: A registration for a slot that is occupied and not being freed in that cycle is ignored and sets `err`. The original entry, including its send timestamp, is kept.
- R10: A notice for a message that is complete but whose arrival pulse is still pending sets `err` and does not add a second pulse.
- R11: `err` is sticky. It becomes 1 in the cycle after an offending input and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register a new outgoing message this cycle |
| reg_msg | input | 3 | Message number to register (table slot) |
| reg_last | input | 2 | Packet count of the message minus one |
| ej_valid | input | 1 | A packet's final flit left the ejection port this cycle |
| ej_msg | input | 3 | Message number the ejected packet belongs to |
| ej_pkt | input | 2 | Packet index within its message |
| arr_valid | output | 1 | One-cycle message arrival pulse |
| arr_msg | output | 3 | Message number of the arrival |
| arr_time | output | 16 | Cycle counter value at the arrival |
| arr_sent | output | 16 | Cycle counter value when the message was registered |
| err | output | 1 | Sticky flag for unmatched notices or refused registrations |

## Verification
The bench builds the tracker with a receiver delay of 3 cycles and the package widths of 8 slots and up to 4 packets per message. This keeps every arrival window short enough to probe cycle by cycle. It also allows a 4-packet message to be delivered out of order and lets two interleaved messages have arrivals in consecutive cycles. With a short delay, a slot can be re-registered in the very cycle its arrival pulse is issued. A single-packet message exercises the rejection of packet indices beyond the declared last one.

// File: rtl/reasm_pkg.sv
package reasm_pkg;

    localparam int MSG_W = 3;
    localparam int PKT_W = 2;
    localparam int TS_W  = 16;
    localparam int NSLOT = 1 << MSG_W;
    localparam int NPKT  = 1 << PKT_W;

    typedef logic [MSG_W-1:0] msg_t;
    typedef logic [PKT_W-1:0] pkt_t;
    typedef logic [PKT_W:0]   left_t;
    typedef logic [TS_W-1:0]  ts_t;

    typedef struct packed {
        logic            busy;
        logic            pend;
        pkt_t            last;
        left_t           left;
        logic [NPKT-1:0] seen;
        ts_t             sent;
    } slot_t;

    typedef struct packed {
        logic vld;
        msg_t msg;
        ts_t  stamp;
        ts_t  sent;
    } evt_t;

    function automatic left_t pkt_count(pkt_t last);
        return left_t'(last) + left_t'(1);
    endfunction

endpackage

// File: rtl/reasm_cycle_ctr.sv
module reasm_cycle_ctr
    import reasm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output ts_t  now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + ts_t'(1);
    end
endmodule

// File: rtl/reasm_slot_table.sv
module reasm_slot_table
    import reasm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reg_valid,
    input  msg_t reg_msg,
    input  pkt_t reg_last,
    input  logic ej_valid,
    input  msg_t ej_msg,
    input  pkt_t ej_pkt,
    input  ts_t  now,
    input  logic free_vld,
    input  msg_t free_msg,
    output evt_t done_evt,
    output logic err
);
    slot_t tbl_q [NSLOT];
    slot_t tbl_d [NSLOT];
    slot_t cur;
    logic  ej_ok, ej_bad, ej_final, reg_ok, reg_bad;

    assign cur      = tbl_q[ej_msg];
    assign ej_ok    = ej_valid && cur.busy && !cur.pend &&
                      (ej_pkt <= cur.last) && !cur.seen[ej_pkt];
    assign ej_bad   = ej_valid && !ej_ok;
    assign ej_final = ej_ok && (cur.left == left_t'(1));
    assign reg_ok   = reg_valid &&
                      (!tbl_q[reg_msg].busy || (free_vld && free_msg == reg_msg));
    assign reg_bad  = reg_valid && !reg_ok;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) tbl_d[i] = tbl_q[i];
        if (ej_ok) begin
            tbl_d[ej_msg].seen[ej_pkt] = 1'b1;
            tbl_d[ej_msg].left         = cur.left - left_t'(1);
            if (ej_final) tbl_d[ej_msg].pend = 1'b1;
        end
        if (free_vld) tbl_d[free_msg] = '0;
        if (reg_ok) begin
            tbl_d[reg_msg].busy = 1'b1;
            tbl_d[reg_msg].pend = 1'b0;
            tbl_d[reg_msg].last = reg_last;
            tbl_d[reg_msg].left = pkt_count(reg_last);
            tbl_d[reg_msg].seen = '0;
            tbl_d[reg_msg].sent = now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) tbl_q[i] <= '0;
            err <= 1'b0;
        end else begin
            for (int i = 0; i < NSLOT; i++) tbl_q[i] <= tbl_d[i];
            err <= err | ej_bad | reg_bad;
        end
    end

    always_comb begin
        done_evt.vld   = ej_final;
        done_evt.msg   = ej_msg;
        done_evt.stamp = now;
        done_evt.sent  = cur.sent;
    end
endmodule

// File: rtl/reasm_delay_line.sv
module reasm_delay_line
    import reasm_pkg::*;
#(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst,
    input  evt_t in_evt,
    output evt_t out_evt
);
    evt_t pipe [DELAY];

    generate
        for (genvar s = 0; s < DELAY; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pipe[0] <= '0;
                    end else begin
                        pipe[0]       <= in_evt;
                        pipe[0].stamp <= in_evt.stamp + ts_t'(DELAY);
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign out_evt = pipe[DELAY-1];
endmodule

// File: rtl/reasm_tracker.sv
module reasm_tracker
    import reasm_pkg::*;
#(
    parameter int DELAY = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_valid,
    input  logic [MSG_W-1:0] reg_msg,
    input  logic [PKT_W-1:0] reg_last,
    input  logic             ej_valid,
    input  logic [MSG_W-1:0] ej_msg,
    input  logic [PKT_W-1:0] ej_pkt,
    output logic             arr_valid,
    output logic [MSG_W-1:0] arr_msg,
    output logic [TS_W-1:0]  arr_time,
    output logic [TS_W-1:0]  arr_sent,
    output logic             err
);
    ts_t  now_cnt;
    evt_t done_evt;
    evt_t out_evt;

    reasm_cycle_ctr i_ctr (
        .clk (clk),
        .rst (rst),
        .now (now_cnt)
    );

    reasm_slot_table i_tbl (
        .clk       (clk),
        .rst       (rst),
        .reg_valid (reg_valid),
        .reg_msg   (reg_msg),
        .reg_last  (reg_last),
        .ej_valid  (ej_valid),
        .ej_msg    (ej_msg),
        .ej_pkt    (ej_pkt),
        .now       (now_cnt),
        .free_vld  (out_evt.vld),
        .free_msg  (out_evt.msg),
        .done_evt  (done_evt),
        .err       (err)
    );

    reasm_delay_line #(.DELAY(DELAY)) i_dly (
        .clk     (clk),
        .rst     (rst),
        .in_evt  (done_evt),
        .out_evt (out_evt)
    );

    assign arr_valid = out_evt.vld;
    assign arr_msg   = out_evt.msg;
    assign arr_time  = out_evt.stamp;
    assign arr_sent  = out_evt.sent;
endmodule

// File: rtl/reasm_tracker_chk.sv
module reasm_tracker_chk
    import reasm_pkg::*;
#(
    parameter int DELAY = 4
) (
    input logic clk,
    input logic rst,
    input logic arr_valid,
    input msg_t arr_msg,
    input ts_t  arr_time,
    input ts_t  arr_sent,
    input logic err,
    input ts_t  now_cnt
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!arr_valid && !err));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5
    stamp_now_chk: assert property (@(posedge clk) disable iff (rst)
        arr_valid |-> (arr_time == now_cnt));

    // R5
    after_send_chk: assert property (@(posedge clk) disable iff (rst)
        arr_valid |-> ((arr_time - arr_sent) >= ts_t'(DELAY + 1)));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        arr_valid |=> !(arr_valid && arr_msg == $past(arr_msg)));
endmodule

bind reasm_tracker reasm_tracker_chk #(.DELAY(DELAY)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .arr_valid (arr_valid),
    .arr_msg   (arr_msg),
    .arr_time  (arr_time),
    .arr_sent  (arr_sent),
    .err       (err),
    .now_cnt   (now_cnt)
);

// File: tb/test_reasm_tracker.sv
`timescale 1ns/1ps
module test_reasm_tracker;
    localparam int DLY = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic [2:0]  reg_msg = '0;
    logic [1:0]  reg_last = '0;
    logic        ej_valid = 1'b0;
    logic [2:0]  ej_msg = '0;
    logic [1:0]  ej_pkt = '0;
    logic        arr_valid;
    logic [2:0]  arr_msg;
    logic [15:0] arr_time;
    logic [15:0] arr_sent;
    logic        err;

    int checks = 0;
    int failures = 0;
    int tcnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) tcnt <= rst ? 0 : tcnt + 1;

    reasm_tracker #(.DELAY(DLY)) i_reasm_tracker (
        .clk(clk), .rst(rst),
        .reg_valid(reg_valid), .reg_msg(reg_msg), .reg_last(reg_last),
        .ej_valid(ej_valid), .ej_msg(ej_msg), .ej_pkt(ej_pkt),
        .arr_valid(arr_valid), .arr_msg(arr_msg), .arr_time(arr_time),
        .arr_sent(arr_sent), .err(err)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        reg_valid = 1'b0;
        ej_valid  = 1'b0;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic do_reg(input int m, input int last, output int sent);
        reg_valid = 1'b1;
        reg_msg   = 3'(m);
        reg_last  = 2'(last);
        sent      = tcnt;
        step();
        reg_valid = 1'b0;
    endtask

    task automatic do_ej(input int m, input int p, output int t);
        ej_valid = 1'b1;
        ej_msg   = 3'(m);
        ej_pkt   = 2'(p);
        t        = tcnt;
        step();
        ej_valid = 1'b0;
    endtask

    // quiet until t_ej+DLY, then check the pulse; optionally check it ends
    task automatic expect_arr(string req, int m, int sent, int t_ej, bit tail);
        while (tcnt < t_ej + DLY) begin
            check(req, "arr_valid early", int'(arr_valid), 0);
            step();
        end
        check(req, "arr_valid", int'(arr_valid), 1);
        check(req, "arr_msg", int'(arr_msg), m);
        check(req, "arr_time", int'(arr_time), t_ej + DLY);
        check(req, "arr_sent", int'(arr_sent), sent);
        if (tail) begin
            step();
            check(req, "arr_valid after pulse", int'(arr_valid), 0);
        end
    endtask

    task automatic expect_silent(string req, int n);
        for (int i = 0; i < n; i++) begin
            check(req, "no arrival", int'(arr_valid), 0);
            step();
        end
    endtask

    task automatic t_r1_reset();
        do_reset();
        check("R1", "arr_valid", int'(arr_valid), 0);
        check("R1", "err", int'(err), 0);
        check("R5", "counter origin", tcnt, 0);
    endtask

    task automatic t_r3_out_of_order();
        int s, t;
        do_reset();
        do_reg(2, 3, s);
        do_ej(2, 3, t);
        do_ej(2, 1, t);
        do_ej(2, 0, t);
        check("R3", "not yet complete", int'(arr_valid), 0);
        do_ej(2, 2, t);
        expect_arr("R4", 2, s, t, 1'b1);
        check("R2", "err clean", int'(err), 0);
    endtask

    task automatic t_r3_interleave();
        int s3, s5, t, t5, t3;
        do_reset();
        do_reg(3, 1, s3);
        do_reg(5, 1, s5);
        do_ej(5, 1, t);
        do_ej(3, 0, t);
        do_ej(5, 0, t5);
        do_ej(3, 1, t3);
        expect_arr("R3", 5, s5, t5, 1'b0);
        step();
        expect_arr("R3", 3, s3, t3, 1'b1);
        check("R3", "err clean", int'(err), 0);
    endtask

    task automatic t_r7_unknown();
        int s, t;
        do_reset();
        do_ej(6, 0, t);
        check("R7", "err on unknown", int'(err), 1);
        do_reg(6, 0, s);
        do_ej(6, 0, t);
        expect_arr("R7", 6, s, t, 1'b1);
        check("R11", "err still set", int'(err), 1);
    endtask

    task automatic t_r8_dup_range();
        int s, t;
        do_reset();
        do_reg(1, 1, s);
        do_ej(1, 0, t);
        check("R8", "err after first", int'(err), 0);
        do_ej(1, 0, t);
        check("R8", "err on duplicate", int'(err), 1);
        expect_silent("R8", DLY + 1);
        do_ej(1, 1, t);
        expect_arr("R8", 1, s, t, 1'b1);
        do_reset();
        do_reg(2, 0, s);
        do_ej(2, 2, t);
        check("R8", "err on index beyond last", int'(err), 1);
        expect_silent("R8", DLY + 1);
        do_ej(2, 0, t);
        expect_arr("R8", 2, s, t, 1'b1);
    endtask

    task automatic t_r9_busy_reg();
        int s, s2, t;
        do_reset();
        do_reg(4, 1, s);
        step();
        do_reg(4, 0, s2);
        check("R9", "err on busy register", int'(err), 1);
        do_ej(4, 0, t);
        expect_silent("R9", DLY + 1);
        do_ej(4, 1, t);
        expect_arr("R9", 4, s, t, 1'b1);
    endtask

    task automatic t_r10_pending();
        int s, t, t2;
        do_reset();
        do_reg(7, 0, s);
        do_ej(7, 0, t);
        do_ej(7, 0, t2);
        check("R10", "err on pending", int'(err), 1);
        expect_arr("R10", 7, s, t, 1'b1);
        expect_silent("R10", DLY);
    endtask

    task automatic t_r6_free();
        int s, s2, t, t2, tx;
        do_reset();
        do_reg(0, 0, s);
        do_ej(0, 0, t);
        while (tcnt < t + DLY) step();
        check("R6", "arrival", int'(arr_valid), 1);
        do_reg(0, 1, s2);
        check("R6", "err after reuse in arrival cycle", int'(err), 0);
        do_ej(0, 1, tx);
        do_ej(0, 0, t2);
        check("R6", "err clean", int'(err), 0);
        expect_arr("R6", 0, t + DLY, t2, 1'b1);
        check("R6", "reuse send stamp", s2, t + DLY);
        do_ej(0, 0, tx);
        check("R6", "err after free", int'(err), 1);
        expect_silent("R6", DLY + 1);
    endtask

    initial begin
        t_r1_reset();
        t_r3_out_of_order();
        t_r3_interleave();
        t_r7_unknown();
        t_r8_dup_range();
        t_r9_busy_reg();
        t_r10_pending();
        t_r6_free();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule